// File: doc/BRIEF.md
# Oscillator Source Selector and System Clock Divider

This block decides which oscillator paces the system and at what ratio. It samples tick pulses from three oscillators in the system clock domain: an always-running ring oscillator, a ceramic resonator oscillator and an RC oscillator. It emits a one-cycle enable pulse, `sys_en`, at the selected rate. Logic downstream advances only on cycles where `sys_en` is high.

An 8-bit control register is written through a simple write strobe and is always visible on `rd_data`.
- Bit 5 picks the external oscillator type.
- Bits 7:6 pick the divider.
- Bits 4:0 are plain storage.

The block always starts on the ring oscillator. Software must switch in a fixed order:
1. Commit the oscillator type.
2. Wait for `osc_stable`, which a tick counter raises.
3. Commit the division ratio.

The type and the ratio are each accepted once per reset.

The divider is a three-state machine:
- `ST_RING` runs from ring ticks.
- `ST_OSC` runs from the selected external oscillator.
- `ST_SWITCH` holds a requested ratio until the running rate emits its next pulse.

The transitions are:
- `ST_RING` → `ST_SWITCH`, and `ST_OSC` → `ST_SWITCH`, when the committed ratio differs from the active one.
- `ST_SWITCH` → `ST_OSC` on that pulse, if the new ratio divides an external oscillator.
- `ST_SWITCH` → `ST_RING` on that pulse, if the new ratio selects the ring.

Top module: `osc_clk_ctrl`

## Requirements
- R1: After reset the register reads 0x80, `osc_stable` is low and `sys_en` pulses once per ring tick.
- R2: Bit 5 = 0 selects ceramic and 1 selects RC. Bits 7:6 encode the rate: 00 = selected oscillator /1, 01 = /2, 10 = ring oscillator, 11 = /8.
- R3: The first write after reset stores bit 5 and locks it. Later writes leave bit 5 unchanged until the next reset.
- R4: A write to bits 7:6 is accepted only if bit 5 was already locked before that write and `osc_stable` is high. A rejected write leaves bits 7:6 unchanged, keeps the ring rate, and does not use up the one allowed update.
- R5: Once a write to bits 7:6 is accepted, those bits ignore all later writes until reset.
- R6: Code 00 in bits 7:6 is rejected while bit 5 is 1 (RC).
- R7: Bits 4:0 take every write, and `rd_data` always shows the stored register value.
- R8: `osc_stable` rises after STABLE_TICKS ticks of the oscillator selected by bit 5. It drops at once when bit 5 changes value.
- R9: A new rate takes effect only in the cycle the running rate emits a pulse. Switching from ring (period 3) to ceramic /2 (period 2 per tick) never produces a pulse gap below 3 cycles.
- R10: `sys_en` is high for one cycle, one clock after the source tick that completes the count. Its steady spacing equals the ratio times the source tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_tick | input | 1 | Ring oscillator tick, one cycle wide |
| cer_tick | input | 1 | Ceramic oscillator tick, one cycle wide |
| rc_tick | input | 1 | RC oscillator tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| osc_stable | output | 1 | Selected oscillator has run STABLE_TICKS ticks |
| sys_en | output | 1 | System clock-enable pulse |

## Verification
Errors in the write locks show up on `rd_data` in the cycle right after the offending write, so the bench checks the readback after every write. A stale or wrong active ratio, or a divider state stuck in `ST_SWITCH`, changes the spacing of `sys_en` within one output period, so the spacing is measured after every accepted or rejected ratio write. A misplaced switch point shows up as a single short gap, and this is caught by tracking the minimum spacing across the change.

// File: rtl/oscclk_pkg.sv
package oscclk_pkg;
    typedef enum logic [1:0] {
        DIV_FULL   = 2'b00,
        DIV_HALF   = 2'b01,
        DIV_RING   = 2'b10,
        DIV_EIGHTH = 2'b11
    } div_sel_e;

    typedef enum logic [1:0] {
        ST_RING   = 2'b00,
        ST_SWITCH = 2'b01,
        ST_OSC    = 2'b10
    } div_state_e;

    localparam int          REG_W      = 8;
    localparam int          OSC_BIT    = 5;
    localparam int          DIV_LSB    = 6;
    localparam logic [7:0]  MODE_RESET = 8'h80;
endpackage

// File: rtl/oscclk_modereg.sv
module oscclk_modereg
    import oscclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             stable_i,
    output logic [REG_W-1:0] reg_q,
    output logic             osc_chg
);
    logic osc_lock_q;
    logic div_lock_q;
    logic div_ok;

    always_comb begin
        div_ok = wr_en && osc_lock_q && !div_lock_q && stable_i &&
                 !(reg_q[OSC_BIT] && (wr_data[DIV_LSB+1:DIV_LSB] == DIV_FULL));
        osc_chg = wr_en && !osc_lock_q && (wr_data[OSC_BIT] != reg_q[OSC_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q      <= MODE_RESET;
            osc_lock_q <= 1'b0;
            div_lock_q <= 1'b0;
        end else if (wr_en) begin
            reg_q[OSC_BIT-1:0] <= wr_data[OSC_BIT-1:0];
            if (!osc_lock_q) begin
                reg_q[OSC_BIT] <= wr_data[OSC_BIT];
                osc_lock_q     <= 1'b1;
            end
            if (div_ok) begin
                reg_q[DIV_LSB+1:DIV_LSB] <= wr_data[DIV_LSB+1:DIV_LSB];
                div_lock_q               <= 1'b1;
            end
        end
    end

    // R3
    osc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_lock_q |=> $stable(reg_q[OSC_BIT]));
    // R5
    div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_lock_q |=> $stable(reg_q[DIV_LSB+1:DIV_LSB]));
    // R4
    div_needs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_q[DIV_LSB+1:DIV_LSB]) |-> $past(stable_i));
    // R6
    no_rc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_q[OSC_BIT] && (reg_q[DIV_LSB+1:DIV_LSB] == DIV_FULL)));
endmodule

// File: rtl/oscclk_stab.sv
module oscclk_stab #(
    parameter int STABLE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic stable
);
    localparam int CW = $clog2(STABLE_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STABLE_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (tick && (cnt_q != LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign stable = (cnt_q == LIMIT);

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !stable);
    // R8
    stable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && !restart) |=> stable);
endmodule

// File: rtl/oscclk_divider.sv
module oscclk_divider
    import oscclk_pkg::*;
#(
    parameter int HIGH_DIV = 2,
    parameter int MID_DIV  = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ring_tick,
    input  logic     osc_tick,
    input  div_sel_e req_sel,
    output logic     sys_en
);
    localparam int CNT_W = $clog2(MID_DIV);

    div_state_e        state_q, state_d;
    div_sel_e          act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last;
    logic              src_tick;
    logic              pulse;

    always_comb begin
        unique case (act_q)
            DIV_HALF:   last = CNT_W'(HIGH_DIV - 1);
            DIV_EIGHTH: last = CNT_W'(MID_DIV - 1);
            default:    last = '0;
        endcase
        src_tick = (act_q == DIV_RING) ? ring_tick : osc_tick;
        pulse    = src_tick && (cnt_q == last);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RING, ST_OSC: if (req_sel != act_q) state_d = ST_SWITCH;
            ST_SWITCH:       if (pulse) state_d = (req_sel == DIV_RING) ? ST_RING : ST_OSC;
            default:         state_d = ST_RING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RING;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= DIV_RING;
            cnt_q  <= '0;
            sys_en <= 1'b0;
        end else begin
            sys_en <= pulse;
            if (pulse) begin
                cnt_q <= '0;
                if (state_q == ST_SWITCH) act_q <= req_sel;
            end else if (src_tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9
    switch_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> sys_en);
    // R10
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |-> $past(ring_tick || osc_tick));
    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && act_q != DIV_FULL && act_q != DIV_RING) |=> !sys_en);
endmodule

// File: rtl/osc_clk_ctrl.sv
module osc_clk_ctrl
    import oscclk_pkg::*;
#(
    parameter int STABLE_TICKS = 16,
    parameter int HIGH_DIV     = 2,
    parameter int MID_DIV      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_tick,
    input  logic       cer_tick,
    input  logic       rc_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       osc_stable,
    output logic       sys_en
);
    logic [REG_W-1:0] reg_q;
    logic             osc_chg;
    logic             osc_tick;
    div_sel_e         req_sel;

    assign osc_tick = reg_q[OSC_BIT] ? rc_tick : cer_tick;
    assign req_sel  = div_sel_e'(reg_q[DIV_LSB+1:DIV_LSB]);
    assign rd_data  = reg_q;

    oscclk_modereg i_modereg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .stable_i (osc_stable),
        .reg_q    (reg_q),
        .osc_chg  (osc_chg)
    );

    oscclk_stab #(.STABLE_TICKS(STABLE_TICKS)) i_stab (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (osc_chg),
        .tick    (osc_tick),
        .stable  (osc_stable)
    );

    oscclk_divider #(.HIGH_DIV(HIGH_DIV), .MID_DIV(MID_DIV)) i_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_tick (ring_tick),
        .osc_tick  (osc_tick),
        .req_sel   (req_sel),
        .sys_en    (sys_en)
    );
endmodule

// File: tb/test_osc_clk_ctrl.sv
module test_osc_clk_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    kind;
        int    exp;
        string tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ring_tick = 1'b0, cer_tick = 1'b0, rc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       osc_stable, sys_en;

    int checks = 0, failures = 0, cyc = 0, tcnt = 0;
    bit done = 0;
    sb_item_t sb_q[$];

    osc_clk_ctrl i_osc_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .ring_tick(ring_tick), .cer_tick(cer_tick),
        .rc_tick(rc_tick), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .osc_stable(osc_stable), .sys_en(sys_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // oscillator ticks: ring every 3, ceramic every 2, RC every 5 cycles
    initial forever begin
        @(negedge clk);
        tcnt++;
        ring_tick = (tcnt % 3 == 0);
        cer_tick  = (tcnt % 2 == 0);
        rc_tick   = (tcnt % 5 == 0);
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL R0 watchdog expired: actual=%0d expected<=150000", cyc);
            report();
        end
    end

    task automatic gap(output int g);
        do @(negedge clk); while (!sys_en);
        g = 0;
        do begin @(negedge clk); g++; end while (!sys_en);
    endtask

    // monitor: pops expected items and compares against observed behaviour
    initial forever begin
        sb_item_t it;
        int act;
        bit ok;
        wait (sb_q.size() != 0);
        it = sb_q[0];
        act = 0;
        case (it.kind)
            0: begin @(negedge clk); act = int'(rd_data); ok = (act == it.exp); end
            1: begin @(negedge clk); act = int'(osc_stable); ok = (act == it.exp); end
            2: begin int g; gap(g); gap(g); act = g; ok = (act == it.exp); end
            default: begin
                act = 1000;
                for (int k = 0; k < 6; k++) begin
                    int g;
                    gap(g);
                    if (g < act) act = g;
                end
                ok = (act >= it.exp);
            end
        endcase
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", it.tag, act, it.exp);
        end
        void'(sb_q.pop_front());
    end

    task automatic expect_item(int kind, int exp, string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_stable();
        while (!osc_stable) @(negedge clk);
    endtask

    initial begin
        // scenario A: ceramic, ordered switch to /2
        do_reset();
        expect_item(0, 'h80, "R1 reset value");
        expect_item(1, 0, "R1 stable low after reset");
        wr(8'h00);
        wr(8'h41);
        expect_item(0, 'h81, "R4 divide held off before stable, R7 low bits");
        expect_item(1, 0, "R8 not yet stable");
        wr(8'h20);
        expect_item(0, 'h80, "R3 oscillator bit locked");
        expect_item(2, 3, "R4 still on ring");
        wait_stable();
        expect_item(1, 1, "R8 stable after ceramic ticks");
        wr(8'h41);
        expect_item(3, 3, "R9 no short gap across switch");
        expect_item(0, 'h41, "R4 divide accepted after stable");
        expect_item(2, 4, "R2 ceramic /2 spacing");
        wr(8'hC3);
        expect_item(0, 'h43, "R5 divide locked, R7 low bits written");
        expect_item(2, 4, "R5 rate unchanged");

        // scenario B: RC mode
        do_reset();
        wr(8'h20);
        expect_item(0, 'hA0, "R3 RC selected by first write");
        expect_item(1, 0, "R8 restart on oscillator change");
        wait_stable();
        wr(8'h20);
        expect_item(0, 'hA0, "R6 /1 rejected in RC");
        expect_item(2, 3, "R6 ring kept");
        wr(8'hE0);
        expect_item(0, 'hE0, "R6 rejection did not lock divide");
        expect_item(2, 40, "R2 RC /8 spacing");

        // scenario C: ceramic /1, then reset
        do_reset();
        wr(8'h00);
        wait_stable();
        wr(8'h00);
        expect_item(0, 'h00, "R2 ceramic /1 accepted");
        expect_item(2, 2, "R2 ceramic /1 spacing");
        do_reset();
        expect_item(0, 'h80, "R1 reset restores value");
        expect_item(2, 3, "R10 one pulse per ring tick");

        done = 1;
        report();
    end
endmodule